// File: doc/BRIEF.md
# Token and Credit Stage Controller

This block decides when one stage of a pipeline may begin an iteration. Upstream neighbours announce new data with single-cycle token pulses. Downstream neighbours announce freed buffer space with single-cycle credit pulses. The controller keeps a saturating count of each. It fires a one-cycle start when four things hold: the stage is idle, at least one token is held, at least one credit is held, and the local input FIFO reports that it can supply operands. The start consumes one token and one credit.

When the stage reports completion, the controller sends one token pulse forward and one credit pulse backward, each one cycle long. Because the controller speaks the same pulse language on both sides, its outputs can drive the inputs of another copy of itself. Stages chain this way to any nesting depth, with no ready/valid handshake anywhere.

After reset the credit count equals the downstream buffer depth, which is a parameter between 1 and 8. A pulse that would push a count past its ceiling is dropped, and a sticky error flag records the loss.

Top module: `tcc_stage_ctrl`

## Requirements
- R1: After reset, tok_cnt is 0, cred_cnt equals CREDIT_INIT, busy is 0, both error flags are 0, and stage_start, tok_out and cred_out are 0.
- R2: A tok_in pulse in a cycle without a start raises tok_cnt by one at the next clock edge, provided tok_cnt is below TOK_MAX.
- R3: A cred_in pulse in a cycle without a start raises cred_cnt by one at the next clock edge, provided cred_cnt is below CREDIT_INIT.
- R4: stage_start is 1 in a cycle exactly when busy is 0, tok_cnt is nonzero, cred_cnt is nonzero and fifo_ok is 1. It is combinational from those values.
- R5: A start lowers tok_cnt and cred_cnt by one each and sets busy, all at the next edge.
- R6: An incoming pulse in the same cycle as a start leaves that counter unchanged and raises no error.
- R7: tok_cnt never exceeds TOK_MAX. A tok_in pulse while tok_cnt equals TOK_MAX and no start occurs leaves the count at TOK_MAX and sets err_tok_ovf, which stays 1 until reset.
- R8: cred_cnt never exceeds CREDIT_INIT. A cred_in pulse while cred_cnt equals CREDIT_INIT and no start occurs leaves the count there and sets err_cred_ovf, which stays 1 until reset.
- R9: stage_done while busy is 1 makes tok_out and cred_out 1 for exactly the next cycle and clears busy at the same edge.
- R10: stage_done while busy is 0 is ignored: no pulse appears on tok_out or cred_out, and the counts and busy do not change.
- R11: Two controllers chained (tok_out of the first to tok_in of the second, and cred_out of the second to cred_in of the first) pass a token forward and return the credit backward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_in | input | 1 | Token pulse from upstream (data available) |
| cred_in | input | 1 | Credit pulse from downstream (space freed) |
| fifo_ok | input | 1 | Local input FIFO can supply one iteration |
| stage_done | input | 1 | Stage finished its current iteration |
| stage_start | output | 1 | Begin one iteration this cycle |
| busy | output | 1 | An iteration is in flight |
| tok_out | output | 1 | Token pulse to downstream |
| cred_out | output | 1 | Credit pulse to upstream |
| tok_cnt | output | $clog2(TOK_MAX+1) | Held tokens |
| cred_cnt | output | $clog2(CREDIT_MAX+1) | Held credits |
| err_tok_ovf | output | 1 | Sticky: a token was dropped at saturation |
| err_cred_ovf | output | 1 | Sticky: a credit was dropped at saturation |

## Verification
The assertions assume that every token and credit input is a one-cycle pulse. They also assume that stage_done arrives only in a cycle after the start it answers, never in the same cycle as that start. The directed stimulus drives each pulse for a single cycle and raises stage_done only after busy has been seen as 1. The one exception is the test of R10, which deliberately raises stage_done while the stage is idle. The overflow tests push a counter past its ceiling on purpose, and the error flags they raise are exactly what the bench checks.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    // What a counter does at the next edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } cnt_act_e;

    // A coincident pulse and consume cancel each other out
    function automatic cnt_act_e tcc_pick_act(input logic up, input logic down);
        if (up && !down)
            return ACT_UP;
        else if (down && !up)
            return ACT_DOWN;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/tcc_sat_counter.sv
module tcc_sat_counter #(
    parameter int MAX_VAL  = 8,
    parameter int INIT_VAL = 0,
    parameter int CNT_W    = $clog2(MAX_VAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up,
    input  logic             down,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    import tcc_pkg::*;

    localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(MAX_VAL);
    localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT_VAL);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    cnt_act_e   act;

    always_comb begin
        st_d = st_q;
        act  = tcc_pick_act(up, down);
        unique case (act)
            ACT_UP: begin
                if (st_q.cnt == MAX_V)
                    st_d.ovf = 1'b1;
                else
                    st_d.cnt = st_q.cnt + ONE_V;
            end
            ACT_DOWN: begin
                if (st_q.cnt != '0)
                    st_d.cnt = st_q.cnt - ONE_V;
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= INIT_V;
            st_q.ovf <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign ovf   = st_q.ovf;

endmodule

// File: rtl/tcc_issue.sv
module tcc_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic tok_avail,
    input  logic cred_avail,
    input  logic fifo_ok,
    input  logic stage_done,
    output logic start,
    output logic busy,
    output logic tok_pulse,
    output logic cred_pulse
);

    typedef struct packed {
        logic busy;
        logic tok_p;
        logic cred_p;
    } iss_state_t;

    iss_state_t st_d, st_q;
    logic       go;
    logic       finish;

    always_comb begin
        go     = !st_q.busy && tok_avail && cred_avail && fifo_ok;
        finish = st_q.busy && stage_done;
        st_d        = st_q;
        st_d.tok_p  = finish;
        st_d.cred_p = finish;
        if (go)
            st_d.busy = 1'b1;
        else if (finish)
            st_d.busy = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign start      = go;
    assign busy       = st_q.busy;
    assign tok_pulse  = st_q.tok_p;
    assign cred_pulse = st_q.cred_p;

endmodule

// File: rtl/tcc_stage_ctrl.sv
module tcc_stage_ctrl #(
    parameter int TOK_MAX     = 8,
    parameter int CREDIT_MAX  = 8,
    parameter int CREDIT_INIT = 4,
    localparam int TW = $clog2(TOK_MAX + 1),
    localparam int CW = $clog2(CREDIT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tok_in,
    input  logic          cred_in,
    input  logic          fifo_ok,
    input  logic          stage_done,
    output logic          stage_start,
    output logic          busy,
    output logic          tok_out,
    output logic          cred_out,
    output logic [TW-1:0] tok_cnt,
    output logic [CW-1:0] cred_cnt,
    output logic          err_tok_ovf,
    output logic          err_cred_ovf
);

    initial begin
        if (CREDIT_INIT < 1 || CREDIT_INIT > CREDIT_MAX)
            $error("CREDIT_INIT out of range");
    end

    logic start_w;

    // Tokens: data available upstream
    tcc_sat_counter #(
        .MAX_VAL (TOK_MAX),
        .INIT_VAL(0),
        .CNT_W   (TW)
    ) u_tok (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (tok_in),
        .down (start_w),
        .count(tok_cnt),
        .ovf  (err_tok_ovf)
    );

    // Credits: free slots downstream, capped at the buffer depth
    tcc_sat_counter #(
        .MAX_VAL (CREDIT_INIT),
        .INIT_VAL(CREDIT_INIT),
        .CNT_W   (CW)
    ) u_cred (
        .clk  (clk),
        .rst_n(rst_n),
        .up   (cred_in),
        .down (start_w),
        .count(cred_cnt),
        .ovf  (err_cred_ovf)
    );

    tcc_issue u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_avail (tok_cnt != '0),
        .cred_avail(cred_cnt != '0),
        .fifo_ok   (fifo_ok),
        .stage_done(stage_done),
        .start     (start_w),
        .busy      (busy),
        .tok_pulse (tok_out),
        .cred_pulse(cred_out)
    );

    assign stage_start = start_w;

endmodule

// File: rtl/tcc_stage_ctrl_chk.sv
module tcc_stage_ctrl_chk #(
    parameter int TOK_MAX     = 8,
    parameter int CREDIT_INIT = 4,
    parameter int TW          = 4,
    parameter int CW          = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tok_in,
    input logic          cred_in,
    input logic          fifo_ok,
    input logic          stage_done,
    input logic          stage_start,
    input logic          busy,
    input logic          tok_out,
    input logic          cred_out,
    input logic [TW-1:0] tok_cnt,
    input logic [CW-1:0] cred_cnt,
    input logic          err_tok_ovf,
    input logic          err_cred_ovf
);
    localparam logic [TW-1:0] TMAX = TW'(TOK_MAX);
    localparam logic [CW-1:0] CMAX = CW'(CREDIT_INIT);

    p_start_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stage_start |-> (!busy && tok_cnt != '0 && cred_cnt != '0 && fifo_ok));

    p_tok_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_in && !stage_start && tok_cnt != TMAX) |=> tok_cnt == $past(tok_cnt) + TW'(1));

    p_cred_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cred_in && !stage_start && cred_cnt != CMAX) |=> cred_cnt == $past(cred_cnt) + CW'(1));

    p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start && !tok_in && !cred_in) |=>
            (busy && tok_cnt == $past(tok_cnt) - TW'(1) && cred_cnt == $past(cred_cnt) - CW'(1)));

    p_cancel_tok_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start && tok_in) |=> $stable(tok_cnt));

    p_cancel_cred_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start && cred_in) |=> $stable(cred_cnt));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tok_cnt <= TMAX);

    p_tok_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_tok_ovf |=> err_tok_ovf);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cred_cnt <= CMAX);

    p_cred_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_cred_ovf |=> err_cred_ovf);

    p_finish_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_done && busy) |=> (tok_out && cred_out && !busy));

    p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out);

    p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_done && !busy) |=> (!tok_out && !cred_out));

endmodule

bind tcc_stage_ctrl tcc_stage_ctrl_chk #(
    .TOK_MAX    (TOK_MAX),
    .CREDIT_INIT(CREDIT_INIT),
    .TW         (TW),
    .CW         (CW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_in      (tok_in),
    .cred_in     (cred_in),
    .fifo_ok     (fifo_ok),
    .stage_done  (stage_done),
    .stage_start (stage_start),
    .busy        (busy),
    .tok_out     (tok_out),
    .cred_out    (cred_out),
    .tok_cnt     (tok_cnt),
    .cred_cnt    (cred_cnt),
    .err_tok_ovf (err_tok_ovf),
    .err_cred_ovf(err_cred_ovf)
);

// File: tb/sim_tcc_stage_ctrl.sv
`timescale 1ns/1ps
module sim_tcc_stage_ctrl;
    localparam int TOK_MAX = 8;
    localparam int CINIT   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic tok_in = 0, cred_in = 0, fifo_ok = 0, stage_done = 0;
    logic stage_start, busy, tok_out, cred_out, err_tok_ovf, err_cred_ovf;
    logic [3:0] tok_cnt, cred_cnt;

    tcc_stage_ctrl #(.TOK_MAX(TOK_MAX), .CREDIT_INIT(CINIT)) u0 (
        .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .cred_in(cred_in),
        .fifo_ok(fifo_ok), .stage_done(stage_done), .stage_start(stage_start),
        .busy(busy), .tok_out(tok_out), .cred_out(cred_out),
        .tok_cnt(tok_cnt), .cred_cnt(cred_cnt),
        .err_tok_ovf(err_tok_ovf), .err_cred_ovf(err_cred_ovf));

    // Chain: stage A feeds stage B
    logic a_tok = 0, a_ok = 0, a_done = 0, b_ok = 0, b_done = 0;
    logic a_start, a_busy, a_tout, a_cout, a_et, a_ec;
    logic b_start, b_busy, b_tout, b_cout, b_et, b_ec;
    logic [3:0] a_tc, a_cc, b_tc, b_cc;

    tcc_stage_ctrl #(.CREDIT_INIT(CINIT)) ua (
        .clk(clk), .rst_n(rst_n), .tok_in(a_tok), .cred_in(b_cout),
        .fifo_ok(a_ok), .stage_done(a_done), .stage_start(a_start),
        .busy(a_busy), .tok_out(a_tout), .cred_out(a_cout),
        .tok_cnt(a_tc), .cred_cnt(a_cc), .err_tok_ovf(a_et), .err_cred_ovf(a_ec));

    tcc_stage_ctrl #(.CREDIT_INIT(2)) ub (
        .clk(clk), .rst_n(rst_n), .tok_in(a_tout), .cred_in(1'b0),
        .fifo_ok(b_ok), .stage_done(b_done), .stage_start(b_start),
        .busy(b_busy), .tok_out(b_tout), .cred_out(b_cout),
        .tok_cnt(b_tc), .cred_cnt(b_cc), .err_tok_ovf(b_et), .err_cred_ovf(b_ec));

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        tok_in = 0; cred_in = 0; fifo_ok = 0; stage_done = 0;
        a_tok = 0; a_ok = 0; a_done = 0; b_ok = 0; b_done = 0;
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    task automatic pulse_tok(input int n);
        for (int i = 0; i < n; i++) begin
            tok_in = 1; tick(); tok_in = 0;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 tok_cnt", int'(tok_cnt), 0);
        chk("R1 cred_cnt", int'(cred_cnt), CINIT);
        chk("R1 busy", int'(busy), 0);
        chk("R1 errors", int'({err_tok_ovf, err_cred_ovf}), 0);
        chk("R1 pulses", int'({stage_start, tok_out, cred_out}), 0);
    endtask

    task automatic t_count_up();
        do_reset();
        pulse_tok(3);
        chk("R2 three tokens", int'(tok_cnt), 3);
        chk("R4 no start while fifo empty", int'(stage_start), 0);
        // spend one credit, then return it
        fifo_ok = 1; #0.5;
        chk("R4 start fires", int'(stage_start), 1);
        tick(); fifo_ok = 0;
        chk("R5 tok after start", int'(tok_cnt), 2);
        chk("R5 cred after start", int'(cred_cnt), CINIT - 1);
        chk("R5 busy", int'(busy), 1);
        cred_in = 1; tick(); cred_in = 0;
        chk("R3 credit returned", int'(cred_cnt), CINIT);
        chk("R8 no error at ceiling", int'(err_cred_ovf), 0);
    endtask

    task automatic t_done();
        do_reset();
        pulse_tok(1);
        fifo_ok = 1; tick(); fifo_ok = 0;
        chk("R5 busy set", int'(busy), 1);
        #0.5;
        chk("R4 no start while busy", int'(stage_start), 0);
        stage_done = 1; tick(); stage_done = 0;
        chk("R9 tok_out", int'(tok_out), 1);
        chk("R9 cred_out", int'(cred_out), 1);
        chk("R9 busy cleared", int'(busy), 0);
        tick();
        chk("R9 single-cycle pulses", int'({tok_out, cred_out}), 0);
    endtask

    task automatic t_no_credit();
        do_reset();
        pulse_tok(CINIT + 2);
        for (int i = 0; i < CINIT; i++) begin
            fifo_ok = 1; tick(); fifo_ok = 0;
            stage_done = 1; tick(); stage_done = 0;
        end
        chk("R5 credits spent", int'(cred_cnt), 0);
        chk("R5 tokens left", int'(tok_cnt), 2);
        fifo_ok = 1; #0.5;
        chk("R4 no start without credit", int'(stage_start), 0);
        tick();
        cred_in = 1; tick(); cred_in = 0; #0.5;
        chk("R4 start after credit", int'(stage_start), 1);
        tick(); fifo_ok = 0;
        chk("R5 credit consumed", int'(cred_cnt), 0);
    endtask

    task automatic t_coincide();
        do_reset();
        pulse_tok(1);
        fifo_ok = 1; tok_in = 1; cred_in = 1; #0.5;
        chk("R4 start with coincident pulses", int'(stage_start), 1);
        tick(); fifo_ok = 0; tok_in = 0; cred_in = 0;
        chk("R6 tok unchanged", int'(tok_cnt), 1);
        chk("R6 cred unchanged", int'(cred_cnt), CINIT);
        chk("R6 no error", int'({err_tok_ovf, err_cred_ovf}), 0);
    endtask

    task automatic t_overflow();
        do_reset();
        pulse_tok(TOK_MAX);
        chk("R7 at max", int'(tok_cnt), TOK_MAX);
        chk("R7 no error yet", int'(err_tok_ovf), 0);
        pulse_tok(1);
        chk("R7 saturated", int'(tok_cnt), TOK_MAX);
        chk("R7 error set", int'(err_tok_ovf), 1);
        tick(); tick();
        chk("R7 error sticky", int'(err_tok_ovf), 1);
        cred_in = 1; tick(); cred_in = 0;
        chk("R8 cred saturated", int'(cred_cnt), CINIT);
        chk("R8 error set", int'(err_cred_ovf), 1);
    endtask

    task automatic t_idle_done();
        do_reset();
        pulse_tok(2);
        stage_done = 1; tick(); stage_done = 0;
        chk("R10 no tok_out", int'(tok_out), 0);
        chk("R10 no cred_out", int'(cred_out), 0);
        chk("R10 busy", int'(busy), 0);
        chk("R10 counts", int'({tok_cnt, cred_cnt}), int'({4'd2, 4'(CINIT)}));
    endtask

    task automatic t_chain();
        do_reset();
        a_tok = 1; tick(); a_tok = 0;
        a_ok = 1; tick(); a_ok = 0;
        chk("R11 A credit spent", int'(a_cc), CINIT - 1);
        a_done = 1; tick(); a_done = 0;
        chk("R11 A tok_out", int'(a_tout), 1);
        tick();
        chk("R11 B got token", int'(b_tc), 1);
        b_ok = 1; tick(); b_ok = 0;
        chk("R11 B busy", int'(b_busy), 1);
        b_done = 1; tick(); b_done = 0;
        chk("R11 B cred_out", int'(b_cout), 1);
        tick();
        chk("R11 A credit restored", int'(a_cc), CINIT);
    endtask

    initial begin
        t_reset();
        t_count_up();
        t_done();
        t_no_credit();
        t_coincide();
        t_overflow();
        t_idle_done();
        t_chain();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule